// File: doc/BRIEF.md
# Configurable symmetric logic cell

This block is one tile of a fine-grained programmable array. A static configuration word, held steady while the array runs, decides which neighbour inputs the cell listens to, whether a local bus joins the logic, how the result leaves the cell and which buses it drives. The cell has four neighbours (north, east, south, west). From each it receives one A bit and one B bit. It returns a single A bit and a single B bit, and all four neighbours see the same pair. Two north-south and two east-west local buses pass through the cell. Each bus appears as an input value plus an output value with an enable, which stands in for a tristate driver.

Inside, an A-side selector and a B-side selector each pick a neighbour or a constant one. The A-side pick is ANDed with an optional bus operand to give the left term. The B-side pick is the right term. A two-bit function code then routes these terms to the outputs in one of four ways: straight through, crossed over, XOR/NAND, or XOR captured in a flip-flop with the AND alongside it. The flip-flop runs on the external clock. An active-low asynchronous reset clears it, and the same reset is applied at power-up.

Top module: `sym_logic_cell`

Configuration word `cfg` (19 bits): `[1:0]` function code, `[4:2]` A pick, `[7:5]` B pick, `[10:8]` bus read, `[13:11]` bus write, `[14]` gated write, `[15]` turn 1 enable, `[16]` turn 1 direction, `[17]` turn 2 enable, `[18]` turn 2 direction. Bus index: 0 = NS1, 1 = EW1, 2 = NS2, 3 = EW2. Neighbour index: 0 = N, 1 = E, 2 = S, 3 = W.

## Requirements
- R1: A pick codes 0..3 select `a_in[code]`. Codes 4..7 give constant 1.
- R2: B pick codes 0..3 select `b_in[code]`. Codes 4..7 give constant 1. The result is the right term.
- R3: The left term is the A pick ANDed with the read operand. A bus read code k in 1..4 uses `bus_in[k-1]`. Codes 0 and 5..7 use constant 1.
- R4: Function code 0 drives `a_out` with the left term and `b_out` with the right term.
- R5: Function code 1 crosses the terms: `a_out` is the right term and `b_out` is the left term.
- R6: Function code 2 drives `a_out` with left XOR right and `b_out` with left NAND right.
- R7: Function code 3 drives `b_out` with left AND right. `a_out` is a flip-flop that loads left XOR right on each rising clock edge, so it changes one edge after its inputs change.
- R8: While `rst_n` is low the flip-flop holds 0 with no clock edge needed, so `a_out` reads 0 under function code 3.
- R9: A bus write code k in 1..4 drives `bus_out[k-1]` with `a_out`. With the gated-write bit at 0 the driver is always enabled. With it at 1, `bus_oe[k-1]` follows the B pick.
- R10: Turn 1 links NS1 and EW1. Direction 0 copies `bus_in[0]` onto bus 1, and direction 1 copies `bus_in[1]` onto bus 0. Turn 2 does the same for NS2 (2) and EW2 (3).
- R11: Any bus that is neither written nor the target of a turn has `bus_oe` low and `bus_out` low. A configuration is legal only if no bus is used by more than one read, write or turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flop |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg | input | 19 | Static configuration word |
| a_in | input | 4 | A bits from N, E, S, W |
| b_in | input | 4 | B bits from N, E, S, W |
| bus_in | input | 4 | Current values of NS1, EW1, NS2, EW2 |
| a_out | output | 1 | A bit to all neighbours |
| b_out | output | 1 | B bit to all neighbours |
| bus_out | output | 4 | Value the cell puts on each bus |
| bus_oe | output | 4 | Drive enable for each bus |

## Verification
Every output is combinational from the inputs and configuration except the registered `a_out` under function code 3. That output is due one rising edge after its operands settle. The bench changes inputs only on falling edges and checks combinational results two nanoseconds later, within the same low phase. For the registered path it checks before the next rising edge that the old value still holds, then checks again after that edge that the new value has appeared. The reset check lowers `rst_n` between edges, so the clear is seen without any clock edge.

// File: rtl/sym_logic_cell.sv
module sym_logic_cell #(
  parameter int CFG_W = 19,
  parameter int NBR   = 4,
  parameter int NBUS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic [NBR-1:0]   a_in,
  input  logic [NBR-1:0]   b_in,
  input  logic [NBUS-1:0]  bus_in,
  output logic             a_out,
  output logic             b_out,
  output logic [NBUS-1:0]  bus_out,
  output logic [NBUS-1:0]  bus_oe
);
  logic [1:0] fn;
  logic [2:0] a_sel, b_sel, rd_sel, wr_sel;
  logic       wr_gated, t1_en, t1_dir, t2_en, t2_dir;

  assign fn       = cfg[1:0];
  assign a_sel    = cfg[4:2];
  assign b_sel    = cfg[7:5];
  assign rd_sel   = cfg[10:8];
  assign wr_sel   = cfg[13:11];
  assign wr_gated = cfg[14];
  assign t1_en    = cfg[15];
  assign t1_dir   = cfg[16];
  assign t2_en    = cfg[17];
  assign t2_dir   = cfg[18];

  logic a_pick, b_pick, rd_op, gate_l, gate_r, q;
  logic [2:0] rd_m1, wr_m1;

  assign rd_m1  = rd_sel - 3'd1;
  assign wr_m1  = wr_sel - 3'd1;
  assign a_pick = a_sel[2] ? 1'b1 : a_in[a_sel[1:0]];
  assign b_pick = b_sel[2] ? 1'b1 : b_in[b_sel[1:0]];
  assign rd_op  = (rd_sel inside {[3'd1:3'd4]}) ? bus_in[rd_m1[1:0]] : 1'b1;
  assign gate_l = a_pick & rd_op;
  assign gate_r = b_pick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 1'b0;
    else        q <= gate_l ^ gate_r;

  always_comb begin
    case (fn)
      2'd0:    begin a_out = gate_l;          b_out = gate_r;            end
      2'd1:    begin a_out = gate_r;          b_out = gate_l;            end
      2'd2:    begin a_out = gate_l ^ gate_r; b_out = ~(gate_l & gate_r); end
      default: begin a_out = q;               b_out = gate_l & gate_r;   end
    endcase
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = '0;
    if (t1_en) begin
      if (!t1_dir) begin bus_out[1] = bus_in[0]; bus_oe[1] = 1'b1; end
      else         begin bus_out[0] = bus_in[1]; bus_oe[0] = 1'b1; end
    end
    if (t2_en) begin
      if (!t2_dir) begin bus_out[3] = bus_in[2]; bus_oe[3] = 1'b1; end
      else         begin bus_out[2] = bus_in[3]; bus_oe[2] = 1'b1; end
    end
    if (wr_sel inside {[3'd1:3'd4]}) begin
      bus_out[wr_m1[1:0]] = a_out;
      bus_oe[wr_m1[1:0]]  = wr_gated ? b_pick : 1'b1;
    end
  end
endmodule

// File: rtl/sym_logic_cell_chk.sv
module sym_logic_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fn,
  input logic [2:0] wr_sel,
  input logic       wr_gated,
  input logic       t1_en,
  input logic       t2_en,
  input logic       gate_l,
  input logic       gate_r,
  input logic       b_pick,
  input logic       a_out,
  input logic       b_out,
  input logic [3:0] bus_oe
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_CROSS_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
    fn == 2'd1 |-> (a_out == gate_r && b_out == gate_l)); // R5

  AST_XOR_NAND: assert property (@(posedge clk) disable iff (!rst_n)
    fn == 2'd2 |-> (a_out == (gate_l ^ gate_r) && b_out == !(gate_l && gate_r))); // R6

  AST_REG_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fn == 2'd3 && $past(fn) == 2'd3) |-> a_out == $past(gate_l ^ gate_r)); // R7

  AST_IDLE_BUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == 3'd0 && !t1_en && !t2_en) |-> bus_oe == 4'd0); // R11

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gated && wr_sel inside {[3'd1:3'd4]} && !b_pick && !t1_en && !t2_en) |-> bus_oe == 4'd0); // R9
endmodule

bind sym_logic_cell sym_logic_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fn(fn), .wr_sel(wr_sel), .wr_gated(wr_gated),
  .t1_en(t1_en), .t2_en(t2_en), .gate_l(gate_l), .gate_r(gate_r),
  .b_pick(b_pick), .a_out(a_out), .b_out(b_out), .bus_oe(bus_oe)
);

// File: tb/sym_logic_cell_tb.sv
module sym_logic_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] cfg = '0;
  logic [3:0]  a_in = '0, b_in = '0, bus_in = '0;
  logic        a_out, b_out;
  logic [3:0]  bus_out, bus_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sym_logic_cell u_dut (.clk(clk), .rst_n(rst_n), .cfg(cfg), .a_in(a_in), .b_in(b_in),
    .bus_in(bus_in), .a_out(a_out), .b_out(b_out), .bus_out(bus_out), .bus_oe(bus_oe));

  function automatic logic [18:0] mk(input logic [1:0] fn, input logic [2:0] as, bs, rd, wr,
                                     input logic gw, t1, t1d, t2, t2d);
    return {t2d, t2, t1d, t1, gw, wr, rd, bs, as, fn};
  endfunction

  function automatic bit legal(input logic [18:0] c);
    int use_cnt[4];
    for (int i = 0; i < 4; i++) use_cnt[i] = 0;
    if (c[10:8] inside {[1:4]}) use_cnt[c[10:8]-1]++;
    if (c[13:11] inside {[1:4]}) use_cnt[c[13:11]-1]++;
    if (c[15]) begin use_cnt[0]++; use_cnt[1]++; end
    if (c[17]) begin use_cnt[2]++; use_cnt[3]++; end
    for (int i = 0; i < 4; i++) if (use_cnt[i] > 1) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic setc(input logic [18:0] c);
    @(negedge clk);
    chk("R11 legality", 4'(legal(c)), 4'd1);
    cfg = c;
    #2;
  endtask

  task automatic t_reset();
    cfg = mk(2'd3, 3'd4, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0);
    b_in = 4'b0000;
    repeat (2) @(posedge clk);
    #2 chk("R8 reset clear", {3'b0, a_out}, 4'd0);
    chk("R11 reset oe", bus_oe, 4'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_select();
    a_in = 4'b0110; b_in = 4'b1001; bus_in = 4'b0000;
    for (int s = 0; s < 6; s++) begin
      setc(mk(2'd0, 3'(s), 3'(s), 3'd0, 3'd0, 0, 0, 0, 0, 0));
      chk("R1 A pick", {3'b0, a_out}, {3'b0, (s > 3) ? 1'b1 : a_in[s]});
      chk("R2 B pick", {3'b0, b_out}, {3'b0, (s > 3) ? 1'b1 : b_in[s]});
    end
  endtask

  task automatic t_read();
    bus_in = 4'b1010;
    for (int k = 1; k < 5; k++) begin
      setc(mk(2'd0, 3'd4, 3'd4, 3'(k), 3'd0, 0, 0, 0, 0, 0));
      chk("R3 bus operand", {3'b0, a_out}, {3'b0, bus_in[k-1]});
    end
    a_in = 4'b0000;
    setc(mk(2'd0, 3'd0, 3'd4, 3'd2, 3'd0, 0, 0, 0, 0, 0));
    chk("R3 AND with pick", {3'b0, a_out}, 4'd0);
    setc(mk(2'd0, 3'd4, 3'd4, 3'd6, 3'd0, 0, 0, 0, 0, 0));
    chk("R3 no read const", {3'b0, a_out}, 4'd1);
  endtask

  task automatic t_comb_modes();
    bus_in = 4'b0000;
    for (int p = 0; p < 4; p++) begin
      logic l, r;
      l = p[1]; r = p[0];
      a_in = {3'b000, l}; b_in = {3'b000, r};
      setc(mk(2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0));
      chk("R4 pass", {2'b0, a_out, b_out}, {2'b0, l, r});
      setc(mk(2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0));
      chk("R5 cross", {2'b0, a_out, b_out}, {2'b0, r, l});
      setc(mk(2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0));
      chk("R6 xor nand", {2'b0, a_out, b_out}, {2'b0, l ^ r, ~(l & r)});
    end
  endtask

  task automatic t_register();
    a_in = 4'b0001; b_in = 4'b0000;
    setc(mk(2'd3, 3'd0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0));
    @(posedge clk); #2;
    chk("R7 reg load 1", {3'b0, a_out}, 4'd1);
    chk("R7 and term", {3'b0, b_out}, 4'd0);
    @(negedge clk) b_in = 4'b0001;
    #2 chk("R7 held before edge", {3'b0, a_out}, 4'd1);
    chk("R7 and term 11", {3'b0, b_out}, 4'd1);
    @(posedge clk); #2;
    chk("R7 reg load 0", {3'b0, a_out}, 4'd0);
    @(negedge clk) b_in = 4'b0000;
    @(posedge clk); #2;
    chk("R7 reg reload 1", {3'b0, a_out}, 4'd1);
    #3 rst_n = 1'b0;
    #2 chk("R8 async clear", {3'b0, a_out}, 4'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_write();
    a_in = 4'b0000; b_in = 4'b0000; bus_in = 4'b0000;
    setc(mk(2'd0, 3'd4, 3'd4, 3'd0, 3'd3, 0, 0, 0, 0, 0));
    chk("R9 write value", bus_out, 4'b0100);
    chk("R9 write oe", bus_oe, 4'b0100);
    setc(mk(2'd0, 3'd0, 3'd4, 3'd0, 3'd1, 0, 0, 0, 0, 0));
    chk("R9 write zero", bus_out, 4'b0000);
    chk("R9 write zero oe", bus_oe, 4'b0001);
    setc(mk(2'd0, 3'd4, 3'd0, 3'd0, 3'd4, 1, 0, 0, 0, 0));
    chk("R9 gated off", bus_oe, 4'b0000);
    @(negedge clk) b_in = 4'b0001;
    #2 chk("R9 gated on", bus_oe, 4'b1000);
    chk("R9 gated value", bus_out, 4'b1000);
  endtask

  task automatic t_turn();
    bus_in = 4'b0101;
    setc(mk(2'd0, 3'd4, 3'd4, 3'd0, 3'd0, 0, 1, 0, 0, 0));
    chk("R10 turn1 ns->ew", {bus_oe, bus_out} == {4'b0010, 4'b0010} ? 4'd1 : 4'd0, 4'd1);
    bus_in = 4'b0010;
    setc(mk(2'd0, 3'd4, 3'd4, 3'd0, 3'd0, 0, 1, 1, 0, 0));
    chk("R10 turn1 ew->ns", {bus_oe, bus_out} == {4'b0001, 4'b0001} ? 4'd1 : 4'd0, 4'd1);
    bus_in = 4'b1000;
    setc(mk(2'd0, 3'd4, 3'd4, 3'd0, 3'd0, 0, 0, 0, 1, 1));
    chk("R10 turn2 ew->ns", {bus_oe, bus_out} == {4'b0100, 4'b0100} ? 4'd1 : 4'd0, 4'd1);
    bus_in = 4'b0000;
    setc(mk(2'd0, 3'd4, 3'd4, 3'd0, 3'd0, 0, 0, 0, 1, 0));
    chk("R10 turn2 ns->ew low", {bus_oe, bus_out} == {4'b1000, 4'b0000} ? 4'd1 : 4'd0, 4'd1);
  endtask

  task automatic t_idle();
    bus_in = 4'b1111;
    setc(mk(2'd2, 3'd4, 3'd4, 3'd1, 3'd0, 0, 0, 0, 0, 0));
    chk("R11 idle oe", bus_oe, 4'd0);
    chk("R11 idle value", bus_out, 4'd0);
    chk("R11 illegal flagged", 4'(legal(mk(2'd0, 3'd4, 3'd4, 3'd1, 3'd0, 0, 1, 0, 0, 0))), 4'd0);
  endtask

  initial begin
    t_reset();
    t_select();
    t_read();
    t_comb_modes();
    t_register();
    t_write();
    t_turn();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule